// File: doc/BRIEF.md
# Thread Context Swap Engine

This per-core block moves the architected state of one hardware thread context out to, or back in from, a shared off-core store of inactive threads. A central thread controller asks for a swap by naming a context, a thread ID and a direction. The engine asserts a flush for that context and holds its fetch stalled. Once the flush is acknowledged, it feeds the core a stream of pre-decoded micro-operations, one per architected register, entering just before rename. The other context on the core keeps running throughout.

All data passes through a staging buffer that holds one cache block of register values. The buffer is always used in slot order.

On a spill, each completed micro-op writes its register value into the next slot. When the last slot is written, the whole block goes to the interconnect at once, like a cache write-back.

On a fill, the engine asks the interconnect for a block and loads it whole. Each fill micro-op then carries the next slot's value to the core. When the last slot has been used, the engine asks for the next block.

A swap moves the integer registers and then the program counter, which gets the highest register number. The tail of the last block is zero. A one-cycle done pulse closes the swap.

Top module: `thread_swap_engine`

## Requirements
- R1: After reset, and after a reset in the middle of a swap, the block is idle with `swap_req_ready` high and `fetch_stall`, `flush_req`, `uop_valid`, `blk_out_valid`, `blk_req` and `swap_done` all low.
- R2: An accepted request sets only bit `ctx` of `fetch_stall` and raises `flush_req` until `flush_ack`. No micro-op is offered while the flush is pending.
- R3: Micro-ops are offered with `uop_reg` counting 0, 1, ... NUM_REGS-1, each register number exactly once. The program counter is number NUM_REGS-1. `uop_fill` gives the direction (1 = fill) and `uop_ctx` names the swapped context. An offer is held until `uop_ready`.
- R4: On a spill, completion k of the swap is stored in slot k mod SLOTS. A block is offered on `blk_out_data` once its last slot completes, with slot s in bits [s*REG_W +: REG_W]. `xfer_seq` is the block number from 0 and `xfer_tid` is the thread ID. The block is held stable until `blk_out_ready`.
- R5: The final spill block carries the last register (the program counter) in slot 0, and every slot past it reads zero.
- R6: During a spill, the block offers no micro-op whose slot lies in a block beyond the one being filled, until that block has been accepted.
- R7: On a fill, `blk_req` pulses with `xfer_seq` = 0 after the flush acknowledge. After `blk_in_valid` loads a block, each fill micro-op's `uop_data` is the value in the slot that belongs to its register.
- R8: When the last used slot of a fill block completes, `blk_req` pulses once for the next block number. No request follows the block that holds the final register.
- R9: `swap_done` pulses for one cycle, in the cycle after the final spill block is accepted or the final fill completion is presented. In that same cycle `fetch_stall` clears and `swap_req_ready` returns high.
- R10: A completion presented while no micro-op is outstanding, and a block delivery presented while none was requested, leave the buffer contents unchanged.
- R11: While a swap is in progress `swap_req_ready` is low, and a request presented then is not taken up, either during the swap or after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_req_valid | input | 1 | Swap request from the thread controller |
| swap_req_fill | input | 1 | 1 = fill into the core, 0 = spill out |
| swap_req_ctx | input | CTX_W | Hardware context to swap |
| swap_req_tid | input | TID_W | Thread ID for message headers |
| swap_req_ready | output | 1 | Engine idle, request accepted this cycle |
| swap_done | output | 1 | One-cycle swap completion pulse |
| fetch_stall | output | CTX_N | Per-context fetch stall |
| flush_req | output | 1 | Flush request for the swapped context |
| flush_ctx | output | CTX_W | Context to flush |
| flush_ack | input | 1 | Core reports the flush finished |
| uop_valid | output | 1 | Micro-op offered for injection |
| uop_ready | input | 1 | Core takes the offered micro-op |
| uop_fill | output | 1 | Micro-op kind, 1 = fill |
| uop_ctx | output | CTX_W | Context of the micro-op |
| uop_reg | output | RNW | Architected register number |
| uop_data | output | REG_W | Fill value (zero for spills) |
| cmpl_valid | input | 1 | Oldest outstanding micro-op completed |
| cmpl_data | input | REG_W | Register value for a spill completion |
| blk_out_valid | output | 1 | Full spill block offered to the interconnect |
| blk_out_ready | input | 1 | Interconnect accepts the block |
| blk_out_data | output | SLOTS*REG_W | Spill block payload |
| blk_req | output | 1 | Pulse: ready for the next fill block |
| blk_in_valid | input | 1 | Fill block delivered |
| blk_in_data | input | SLOTS*REG_W | Fill block payload |
| xfer_tid | output | TID_W | Header thread ID |
| xfer_seq | output | SEQ_W | Header block number |

## Verification
The vector table runs both directions on both contexts. Some vectors have completions that return right after issue, and others hold them back by up to seven cycles. Toggling injection ready separates the hold-until-taken behaviour from a simple per-cycle issue. A slow block acceptance shows whether the issue window stops at the block boundary.

Register values mix the seed with the register number, so a slot that is shifted, swapped or not padded shows up as a wrong word in a known position. Stray completions during the flush, a block delivered without a request, and a second request during a swap all exercise the paths that must be ignored. A reset in the middle of a swap checks that it returns cleanly to idle.

// File: rtl/tswap_pkg.sv
package tswap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_LOAD,
    ST_RUN,
    ST_SEND
  } tswap_state_e;
endpackage

// File: rtl/tswap_buf.sv
module tswap_buf #(
  parameter int SLOTS = 8,
  parameter int REG_W = 64,
  parameter int SW    = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   ld_en,
  input  logic [SLOTS*REG_W-1:0] ld_data,
  input  logic                   wr_en,
  input  logic [SW-1:0]          wr_idx,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [SW-1:0]          rd_idx,
  output logic [REG_W-1:0]       rd_data,
  output logic [SLOTS*REG_W-1:0] flat
);
  logic [REG_W-1:0] slot_q [SLOTS];

  // One register per slot: the interconnect side needs all slots in one cycle.
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr)
        slot_q[i] <= '0;
      else if (ld_en)
        slot_q[i] <= ld_data[i*REG_W +: REG_W];
      else if (wr_en && wr_idx == SW'(i))
        slot_q[i] <= wr_data;
    end
    assign flat[i*REG_W +: REG_W] = slot_q[i];
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/tswap_ctl.sv
module tswap_ctl
  import tswap_pkg::*;
#(
  parameter int CTX_N    = 2,
  parameter int CTX_W    = 1,
  parameter int TID_W    = 8,
  parameter int REG_W    = 64,
  parameter int SLOTS    = 8,
  parameter int SW       = 3,
  parameter int NUM_REGS = 33,
  parameter int RNW      = 6,
  parameter int SEQ_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap_req_valid,
  input  logic             swap_req_fill,
  input  logic [CTX_W-1:0] swap_req_ctx,
  input  logic [TID_W-1:0] swap_req_tid,
  output logic             swap_req_ready,
  output logic             swap_done,
  output logic [CTX_N-1:0] fetch_stall,
  output logic             flush_req,
  output logic [CTX_W-1:0] flush_ctx,
  input  logic             flush_ack,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic             uop_fill,
  output logic [CTX_W-1:0] uop_ctx,
  output logic [RNW-1:0]   uop_reg,
  output logic [REG_W-1:0] uop_data,
  input  logic             cmpl_valid,
  output logic             blk_out_valid,
  input  logic             blk_out_ready,
  output logic             blk_req,
  input  logic             blk_in_valid,
  output logic [TID_W-1:0] xfer_tid,
  output logic [SEQ_W-1:0] xfer_seq,
  output logic             buf_clr,
  output logic             buf_ld,
  output logic             buf_wr,
  output logic [SW-1:0]    buf_wr_idx,
  output logic [SW-1:0]    buf_rd_idx,
  input  logic [REG_W-1:0] buf_rd_data
);
  tswap_state_e     st;
  logic             fill_q;
  logic [CTX_W-1:0] ctx_q;
  logic [TID_W-1:0] tid_q;
  logic [SEQ_W-1:0] seq_q;
  logic [RNW-1:0]   iss_q;   // next register to offer
  logic [RNW-1:0]   cmp_q;   // registers completed
  logic             can_issue, cmpl_take, last_reg, slot_end;

  assign swap_req_ready = (st == ST_IDLE);
  // Issue window: only registers whose slot lies in the current block.
  assign can_issue  = (st == ST_RUN) && (iss_q < RNW'(NUM_REGS)) &&
                      ((iss_q >> SW) == RNW'(seq_q));
  // A completion counts only if a handed-over micro-op is outstanding.
  assign cmpl_take  = (st == ST_RUN) && cmpl_valid &&
                      ((cmp_q + RNW'(uop_valid)) < iss_q);
  assign last_reg   = (cmp_q == RNW'(NUM_REGS - 1));
  assign slot_end   = (cmp_q[SW-1:0] == SW'(SLOTS - 1)) || last_reg;

  assign buf_clr    = ((st == ST_IDLE) && swap_req_valid) ||
                      ((st == ST_SEND) && blk_out_ready);
  assign buf_ld     = (st == ST_LOAD) && blk_in_valid;
  assign buf_wr     = cmpl_take && !fill_q;
  assign buf_wr_idx = cmp_q[SW-1:0];
  assign buf_rd_idx = iss_q[SW-1:0];

  assign flush_ctx  = ctx_q;
  assign uop_ctx    = ctx_q;
  assign xfer_tid   = tid_q;
  assign xfer_seq   = seq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      fill_q        <= 1'b0;
      ctx_q         <= '0;
      tid_q         <= '0;
      seq_q         <= '0;
      iss_q         <= '0;
      cmp_q         <= '0;
      fetch_stall   <= '0;
      flush_req     <= 1'b0;
      uop_valid     <= 1'b0;
      uop_fill      <= 1'b0;
      uop_reg       <= '0;
      uop_data      <= '0;
      blk_out_valid <= 1'b0;
      blk_req       <= 1'b0;
      swap_done     <= 1'b0;
    end else begin
      swap_done <= 1'b0;
      blk_req   <= 1'b0;

      if (uop_valid && uop_ready)
        uop_valid <= 1'b0;
      if (can_issue && (!uop_valid || uop_ready)) begin
        uop_valid <= 1'b1;
        uop_fill  <= fill_q;
        uop_reg   <= iss_q;
        uop_data  <= fill_q ? buf_rd_data : '0;
        iss_q     <= iss_q + RNW'(1);
      end
      if (cmpl_take)
        cmp_q <= cmp_q + RNW'(1);

      unique case (st)
        ST_IDLE: if (swap_req_valid) begin
          st          <= ST_FLUSH;
          fill_q      <= swap_req_fill;
          ctx_q       <= swap_req_ctx;
          tid_q       <= swap_req_tid;
          seq_q       <= '0;
          iss_q       <= '0;
          cmp_q       <= '0;
          flush_req   <= 1'b1;
          fetch_stall <= CTX_N'(1) << swap_req_ctx;
        end
        ST_FLUSH: if (flush_ack) begin
          flush_req <= 1'b0;
          if (fill_q) begin
            blk_req <= 1'b1;
            st      <= ST_LOAD;
          end else begin
            st <= ST_RUN;
          end
        end
        ST_LOAD: if (blk_in_valid) st <= ST_RUN;
        ST_RUN: if (cmpl_take && slot_end) begin
          if (!fill_q) begin
            st            <= ST_SEND;
            blk_out_valid <= 1'b1;
          end else if (last_reg) begin
            st          <= ST_IDLE;
            swap_done   <= 1'b1;
            fetch_stall <= '0;
          end else begin
            seq_q   <= seq_q + SEQ_W'(1);
            blk_req <= 1'b1;
            st      <= ST_LOAD;
          end
        end
        ST_SEND: if (blk_out_ready) begin
          blk_out_valid <= 1'b0;
          seq_q         <= seq_q + SEQ_W'(1);
          if (cmp_q == RNW'(NUM_REGS)) begin
            st          <= ST_IDLE;
            swap_done   <= 1'b1;
            fetch_stall <= '0;
          end else begin
            st <= ST_RUN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/thread_swap_engine.sv
module thread_swap_engine #(
  parameter int CTX_N       = 2,
  parameter int TID_W       = 8,
  parameter int REG_W       = 64,
  parameter int BLOCK_BYTES = 64,
  parameter int NUM_REGS    = 33,
  localparam int CTX_W      = (CTX_N > 1) ? $clog2(CTX_N) : 1,
  localparam int SLOTS      = BLOCK_BYTES * 8 / REG_W,
  localparam int SW         = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int RNW        = $clog2(NUM_REGS + 1),
  localparam int NBLK       = (NUM_REGS + SLOTS - 1) / SLOTS,
  localparam int SEQ_W      = (NBLK > 1) ? $clog2(NBLK + 1) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   swap_req_valid,
  input  logic                   swap_req_fill,
  input  logic [CTX_W-1:0]       swap_req_ctx,
  input  logic [TID_W-1:0]       swap_req_tid,
  output logic                   swap_req_ready,
  output logic                   swap_done,
  output logic [CTX_N-1:0]       fetch_stall,
  output logic                   flush_req,
  output logic [CTX_W-1:0]       flush_ctx,
  input  logic                   flush_ack,
  output logic                   uop_valid,
  input  logic                   uop_ready,
  output logic                   uop_fill,
  output logic [CTX_W-1:0]       uop_ctx,
  output logic [RNW-1:0]         uop_reg,
  output logic [REG_W-1:0]       uop_data,
  input  logic                   cmpl_valid,
  input  logic [REG_W-1:0]       cmpl_data,
  output logic                   blk_out_valid,
  input  logic                   blk_out_ready,
  output logic [SLOTS*REG_W-1:0] blk_out_data,
  output logic                   blk_req,
  input  logic                   blk_in_valid,
  input  logic [SLOTS*REG_W-1:0] blk_in_data,
  output logic [TID_W-1:0]       xfer_tid,
  output logic [SEQ_W-1:0]       xfer_seq
);
  logic             buf_clr, buf_ld, buf_wr;
  logic [SW-1:0]    buf_wr_idx, buf_rd_idx;
  logic [REG_W-1:0] buf_rd_data;

  tswap_ctl #(
    .CTX_N(CTX_N), .CTX_W(CTX_W), .TID_W(TID_W), .REG_W(REG_W), .SLOTS(SLOTS),
    .SW(SW), .NUM_REGS(NUM_REGS), .RNW(RNW), .SEQ_W(SEQ_W)
  ) ctl_i (
    .clk, .rst,
    .swap_req_valid, .swap_req_fill, .swap_req_ctx, .swap_req_tid,
    .swap_req_ready, .swap_done, .fetch_stall,
    .flush_req, .flush_ctx, .flush_ack,
    .uop_valid, .uop_ready, .uop_fill, .uop_ctx, .uop_reg, .uop_data,
    .cmpl_valid,
    .blk_out_valid, .blk_out_ready, .blk_req, .blk_in_valid,
    .xfer_tid, .xfer_seq,
    .buf_clr, .buf_ld, .buf_wr, .buf_wr_idx, .buf_rd_idx, .buf_rd_data
  );

  tswap_buf #(.SLOTS(SLOTS), .REG_W(REG_W), .SW(SW)) buf_i (
    .clk, .rst,
    .clr(buf_clr),
    .ld_en(buf_ld),
    .ld_data(blk_in_data),
    .wr_en(buf_wr),
    .wr_idx(buf_wr_idx),
    .wr_data(cmpl_data),
    .rd_idx(buf_rd_idx),
    .rd_data(buf_rd_data),
    .flat(blk_out_data)
  );
endmodule

// File: rtl/thread_swap_engine_chk.sv
module thread_swap_engine_chk #(
  parameter int CTX_N    = 2,
  parameter int RNW      = 6,
  parameter int NUM_REGS = 33,
  parameter int BLK_W    = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             swap_req_ready,
  input logic             swap_done,
  input logic [CTX_N-1:0] fetch_stall,
  input logic             flush_req,
  input logic             uop_valid,
  input logic             uop_ready,
  input logic [RNW-1:0]   uop_reg,
  input logic             blk_out_valid,
  input logic             blk_out_ready,
  input logic [BLK_W-1:0] blk_out_data,
  input logic             blk_req
);
  assert_no_uop_in_flush_R2: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> !uop_valid);
  assert_single_stall_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fetch_stall));
  assert_uop_held_R3: assert property (@(posedge clk) disable iff (rst)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_reg));
  assert_uop_reg_range_R3: assert property (@(posedge clk) disable iff (rst)
    uop_valid |-> uop_reg < RNW'(NUM_REGS));
  assert_block_held_R4: assert property (@(posedge clk) disable iff (rst)
    blk_out_valid && !blk_out_ready |=> blk_out_valid && $stable(blk_out_data));
  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    blk_req |=> !blk_req);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    swap_done |=> !swap_done);
  assert_done_releases_R9: assert property (@(posedge clk) disable iff (rst)
    swap_done |-> (fetch_stall == '0) && swap_req_ready);
  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
    (fetch_stall != '0) |-> !swap_req_ready);
endmodule

bind thread_swap_engine thread_swap_engine_chk #(
  .CTX_N(CTX_N), .RNW(RNW), .NUM_REGS(NUM_REGS), .BLK_W(SLOTS*REG_W)
) chk_i (.*);

// File: tb/thread_swap_engine_tb_top.sv
module thread_swap_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CTX_N = 2, CTX_W = 1, TID_W = 8, REG_W = 64, NUM_REGS = 33;
  localparam int SLOTS = 8, RNW = 6, SEQ_W = 3, NBLK = 5;
  localparam int BLK_W = SLOTS * REG_W;

  typedef struct packed {
    logic        fill;
    logic        ctx;
    logic [7:0]  tid;
    logic [31:0] seed;
    logic [3:0]  rdly;
    logic [3:0]  cdly;
    logic        stall;
    logic        busy;
    logic        stray;
    logic [3:0]  exp_xfers;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 8'h11, 32'h1234_5678, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd5},
    '{1'b1, 1'b1, 8'h22, 32'hCAFE_F00D, 4'd0, 4'd2, 1'b0, 1'b0, 1'b0, 4'd5},
    '{1'b0, 1'b1, 8'h33, 32'h0BAD_BEEF, 4'd5, 4'd3, 1'b1, 1'b1, 1'b0, 4'd5},
    '{1'b1, 1'b0, 8'h44, 32'h5555_AAAA, 4'd0, 4'd0, 1'b1, 1'b1, 1'b0, 4'd5},
    '{1'b0, 1'b0, 8'h55, 32'h0F0F_0F0F, 4'd2, 4'd1, 1'b0, 1'b0, 1'b1, 4'd5},
    '{1'b1, 1'b1, 8'hA5, 32'hFFFF_FFFF, 4'd1, 4'd7, 1'b0, 1'b0, 1'b0, 4'd5}
  };

  logic             clk = 1'b0, rst = 1'b1;
  logic             swap_req_valid = 1'b0, swap_req_fill = 1'b0;
  logic [CTX_W-1:0] swap_req_ctx = '0;
  logic [TID_W-1:0] swap_req_tid = '0;
  logic             swap_req_ready, swap_done, flush_req, flush_ack = 1'b0;
  logic [CTX_N-1:0] fetch_stall;
  logic [CTX_W-1:0] flush_ctx, uop_ctx;
  logic             uop_valid, uop_ready = 1'b1, uop_fill;
  logic [RNW-1:0]   uop_reg;
  logic [REG_W-1:0] uop_data, cmpl_data = '0;
  logic             cmpl_valid = 1'b0;
  logic             blk_out_valid, blk_out_ready = 1'b0, blk_req, blk_in_valid = 1'b0;
  logic [BLK_W-1:0] blk_out_data, blk_in_data = '0;
  logic [TID_W-1:0] xfer_tid;
  logic [SEQ_W-1:0] xfer_seq;

  thread_swap_engine dut_i (
    .clk, .rst, .swap_req_valid, .swap_req_fill, .swap_req_ctx, .swap_req_tid,
    .swap_req_ready, .swap_done, .fetch_stall, .flush_req, .flush_ctx, .flush_ack,
    .uop_valid, .uop_ready, .uop_fill, .uop_ctx, .uop_reg, .uop_data,
    .cmpl_valid, .cmpl_data, .blk_out_valid, .blk_out_ready, .blk_out_data,
    .blk_req, .blk_in_valid, .blk_in_data, .xfer_tid, .xfer_seq
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] val(input logic [31:0] seed, input int r);
    if (r >= NUM_REGS) return 64'h0;
    return {seed ^ (32'(r) * 32'h9E37_79B9), 32'hC0DE_0000 | 32'(r)};
  endfunction

  function automatic logic [BLK_W-1:0] build(input logic [31:0] seed, input int b);
    logic [BLK_W-1:0] d;
    for (int s = 0; s < SLOTS; s++) d[s*REG_W +: REG_W] = val(seed, b*SLOTS + s);
    return d;
  endfunction

  task automatic idle_checks(input string tag);
    chk({tag, " ready"}, 64'(swap_req_ready), 64'd1);
    chk({tag, " stall"}, 64'(fetch_stall), 64'd0);
    chk({tag, " flush"}, 64'(flush_req), 64'd0);
    chk({tag, " uop"}, 64'(uop_valid), 64'd0);
    chk({tag, " blkout"}, 64'(blk_out_valid), 64'd0);
    chk({tag, " blkreq"}, 64'(blk_req), 64'd0);
    chk({tag, " done"}, 64'(swap_done), 64'd0);
  endtask

  task automatic run_swap(input vec_t v);
    int cyc = 0, issued = 0, blocks = 0, reqs = 0, qh = 0, qt = 0;
    int q_reg [64];
    int q_t [64];
    int flush_wait = 2, rdy_wait = -1, in_wait = -1, last_evt = -100;
    bit seen_done = 0, probed = 0, stray_a = 0, stray_b = 0;
    string dtag;
    @(negedge clk);
    chk("R11 idle ready before start", 64'(swap_req_ready), 64'd1);
    swap_req_valid = 1'b1; swap_req_fill = v.fill;
    swap_req_ctx = v.ctx;  swap_req_tid = v.tid;
    @(negedge clk);
    while (!seen_done && cyc < 5000) begin
      swap_req_valid = 1'b0; cmpl_valid = 1'b0; blk_in_valid = 1'b0;
      flush_ack = 1'b0; blk_out_ready = 1'b0;
      if (swap_done) begin
        seen_done = 1;
        chk("R9 done timing", 64'(cyc), 64'(last_evt + 1));
        chk("R9 stall cleared", 64'(fetch_stall), 64'd0);
        chk("R9 ready again", 64'(swap_req_ready), 64'd1);
        chk("R3 all registers issued", 64'(issued), 64'(NUM_REGS));
        chk(v.fill ? "R8 fill block count" : "R4 spill block count", 64'(blocks), 64'(v.exp_xfers));
        if (v.fill) chk("R8 request count", 64'(reqs), 64'(v.exp_xfers));
      end else begin
        chk("R2 only swapped context stalled", 64'(fetch_stall), 64'(1 << v.ctx));
      end
      if (flush_req) begin
        chk("R2 no micro-op during flush", 64'(uop_valid), 64'd0);
        chk("R2 flush context", 64'(flush_ctx), 64'(v.ctx));
        if (v.stray && !stray_a) begin
          cmpl_valid = 1'b1; cmpl_data = 64'hDEAD_DEAD_DEAD_DEAD; stray_a = 1;
        end
        if (flush_wait == 0) flush_ack = 1'b1; else flush_wait--;
      end
      // completions, oldest first
      if (qh < qt && q_t[qh] <= cyc) begin
        cmpl_valid = 1'b1;
        cmpl_data  = v.fill ? 64'h0 : val(v.seed, q_reg[qh]);
        if (v.fill && q_reg[qh] == NUM_REGS - 1) last_evt = cyc;
        qh++;
      end
      // injection handshake
      uop_ready = v.stall ? cyc[0] : 1'b1;
      if (uop_valid && uop_ready) begin
        chk(v.fill ? "R7 fill order" : "R3 spill order", 64'(uop_reg), 64'(issued));
        chk("R3 micro-op kind", 64'(uop_fill), 64'(v.fill));
        chk("R3 micro-op context", 64'(uop_ctx), 64'(v.ctx));
        if (v.fill) chk("R7 fill value", uop_data, val(v.seed, issued));
        else chk("R6 issue inside current block", 64'(issued < (blocks + 1) * SLOTS), 64'd1);
        q_reg[qt] = issued; q_t[qt] = cyc + 1 + int'(v.cdly); qt++;
        issued++;
        if (v.busy && !probed) begin
          swap_req_valid = 1'b1; swap_req_ctx = ~v.ctx; probed = 1;
          chk("R11 busy not ready", 64'(swap_req_ready), 64'd0);
        end
      end
      // spill block acceptance
      if (blk_out_valid) begin
        if (v.stray && !stray_b) begin
          blk_in_valid = 1'b1; blk_in_data = '1; stray_b = 1;
        end
        if (rdy_wait < 0) rdy_wait = int'(v.rdly);
        if (rdy_wait == 0) begin
          blk_out_ready = 1'b1;
          chk("R4 block number", 64'(xfer_seq), 64'(blocks));
          chk("R4 block thread id", 64'(xfer_tid), 64'(v.tid));
          for (int s = 0; s < SLOTS; s++) begin
            dtag = v.stray ? "R10 block data after stray input" :
                   (blocks == NBLK - 1) ? "R5 last block data" : "R4 block data";
            chk(dtag, blk_out_data[s*REG_W +: REG_W], val(v.seed, blocks*SLOTS + s));
          end
          blocks++; rdy_wait = -1;
          if (blocks == NBLK) last_evt = cyc;
        end else begin
          rdy_wait--;
        end
      end
      // fill block delivery
      if (in_wait == 0) begin
        blk_in_valid = 1'b1; blk_in_data = build(v.seed, blocks);
        blocks++; in_wait = -1;
      end else if (in_wait > 0) begin
        in_wait--;
      end
      if (blk_req) begin
        chk(reqs == 0 ? "R7 first request number" : "R8 next request number",
            64'(xfer_seq), 64'(blocks));
        chk("R8 request thread id", 64'(xfer_tid), 64'(v.tid));
        reqs++; in_wait = 2;
      end
      @(negedge clk);
      cyc++;
    end
    if (!seen_done) chk("R9 swap never completed", 64'd0, 64'd1);
    swap_req_valid = 1'b0; cmpl_valid = 1'b0; blk_in_valid = 1'b0;
    flush_ack = 1'b0; blk_out_ready = 1'b0; uop_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 no late start", 64'(fetch_stall), 64'd0);
      chk("R8 no request after final block", 64'(blk_req), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_checks("R1 after reset");

    for (int i = 0; i < NVEC; i++) run_swap(VECS[i]);

    // stray completion and block delivery while idle, then a clean spill
    cmpl_valid = 1'b1; cmpl_data = 64'h1111_2222_3333_4444;
    blk_in_valid = 1'b1; blk_in_data = '1;
    @(negedge clk);
    cmpl_valid = 1'b0; blk_in_valid = 1'b0;
    idle_checks("R10 idle after stray inputs");
    run_swap('{1'b0, 1'b1, 8'h66, 32'h7777_0001, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd5});

    // reset in the middle of a spill
    swap_req_valid = 1'b1; swap_req_fill = 1'b0; swap_req_ctx = 1'b0; swap_req_tid = 8'h77;
    @(negedge clk);
    swap_req_valid = 1'b0; flush_ack = 1'b1;
    @(negedge clk);
    flush_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 stall while swapping", 64'(fetch_stall), 64'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_checks("R1 after mid-swap reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule